// File: doc/BRIEF.md
# Serial Read-Out Port for an 8-bit Successive-Approximation Converter

This block is the digital side of a small sampling converter that talks to a host over a three-wire, read-only serial port. A separate analog front end is not modelled. An 8-bit sample word stands in for the conversion result, and the bit decisions are taken from that word. A fast system clock oversamples the host's serial clock, chip select and output-enable lines. Each of these goes through a two-flop synchronizer, and the block works on the edges it detects.

A cycle starts when chip select falls while output enable is low. The port then drives four zero bits. The held sample follows MSB first, one bit per falling serial-clock edge, so the host reads the MSB on its fifth rising edge. The block powers down by itself once the LSB has been read. A coding pin is sampled on the first rising edge of the cycle and selects one of two codings. Unipolar coding passes the sample straight through. Bipolar coding gives two's complement about mid-scale. Output enable high overrides everything and tri-states the port at once.

The tri-state pad is modelled as a data bit plus a drive flag. The sample word and coding pin are plain levels with no handshake and no back-pressure. The sample word is read only at the hold instant, and the host decides the pace by how it clocks.

Top module: `sar8_serial_port`

## Requirements
- R1: After reset the port is powered down: `sdo_en` is 0 and `sdo_bit` is 0.
- R2: A falling edge of `sel_n` while `hiz_req` is low starts a cycle. `sdo_en` goes to 1 with `sdo_bit` 0 before the first serial-clock edge. A fall of `sel_n` while `hiz_req` is high starts nothing.
- R3: Counting falling `ser_clk` edges from the start of a cycle as 1, 2, 3 and so on, the output is 0 up to fall 3. Fall n, for n from 4 to 11, presents code bit 11-n. The host therefore sees four zeros and then bits 7 down to 0 on rising edges 1 to 12.
- R4: The sample word is captured on fall 3. Later changes of `sample_word` do not change the bits sent in that cycle.
- R5: `fmt_unipolar` is captured on the first rising `ser_clk` edge of a cycle. Later changes of it do not affect that cycle.
- R6: With `fmt_unipolar`=1 the code equals the sample. With 0 the code is the sample with bit 7 inverted. Sample 0x80 (mid-scale) gives 0x00, 0xFF gives 0x7F and 0x00 gives 0x80.
- R7: The rising edge after the LSB fall (rising edge 12) powers the port down: `sdo_bit` 0 and `sdo_en` 0.
- R8: Once a cycle has started, `sel_n` returning high does not abort it. Further `sel_n` falls before the cycle completes do not restart it.
- R9: `hiz_req` high drops `sdo_en` combinationally and abandons the cycle. The next `sel_n` fall with `hiz_req` low starts a fresh cycle from fall count 0.
- R10: After a completed cycle, the next `sel_n` fall starts a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host chip select, active low |
| hiz_req | input | 1 | Output-enable pin, high forces power-down and tri-state |
| ser_clk | input | 1 | Host serial clock |
| fmt_unipolar | input | 1 | Coding select: 1 unipolar, 0 bipolar |
| sample_word | input | 8 | Sample value standing in for the analog level (0x80 = mid-scale) |
| sdo_bit | output | 1 | Serial data value |
| sdo_en | output | 1 | Serial data drive flag (0 = high impedance) |

## Verification
The bench builds the block with its defaults: 8 data bits, 4 leading zeros, hold on fall 3 and two synchronizer stages. With a serial half period of eight system clocks, every detected edge settles well before the next one. This brings the whole frame within reach, bit by bit: both codings at the bipolar extremes and mid-scale, and changes of sample and coding pin after the capture points. It also covers a chip-select bounce and release in mid-frame, and an output-enable abort followed by a fresh cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_RUN  = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/ssp_coder.sv
module ssp_coder #(
  parameter int W = 8
) (
  input  logic [W-1:0] sample,
  input  logic         unipolar,
  output logic [W-1:0] code
);
  always_comb begin
    code = sample;
    if (!unipolar) code[W-1] = ~sample[W-1];
  end
endmodule

// File: rtl/sar8_serial_port.sv
module sar8_serial_port #(
  parameter int DATA_W    = 8,
  parameter int LEAD_Z    = 4,
  parameter int HOLD_EDGE = 3,
  parameter int SYNC_ST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              hiz_req,
  input  logic              ser_clk,
  input  logic              fmt_unipolar,
  input  logic [DATA_W-1:0] sample_word,
  output logic              sdo_bit,
  output logic              sdo_en
);
  import ssp_pkg::*;

  localparam int FRAME = LEAD_Z + DATA_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] K_HOLD = CW'(HOLD_EDGE);
  localparam logic [CW-1:0] K_LEAD = CW'(LEAD_Z);
  localparam logic [CW-1:0] K_LAST = CW'(FRAME - 1);

  logic [2:0] pins_s;
  logic       hiz_s, sel_s, sck_s;
  logic [1:0] prev;
  logic       sel_fall, sck_rise, sck_fall;

  ssp_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({hiz_req, sel_n, ser_clk}),
    .q(pins_s)
  );
  assign {hiz_s, sel_s, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b10;
    else        prev <= {sel_s, sck_s};
  end
  assign sel_fall = prev[1] & ~sel_s;
  assign sck_rise = ~prev[0] & sck_s;
  assign sck_fall = prev[0] & ~sck_s;

  phase_t            phase;
  logic [CW-1:0]     fall_cnt, nxt_cnt, bit_pos;
  logic              mode_taken, mode_q, mode_use;
  logic [DATA_W-1:0] held, code;
  logic              data_q, drive_q, sel_bit;

  assign mode_use = mode_taken ? mode_q : fmt_unipolar;

  ssp_coder #(.W(DATA_W)) u_coder (
    .sample(sample_word), .unipolar(mode_use), .code(code)
  );

  assign nxt_cnt = fall_cnt + 1'b1;
  assign bit_pos = K_LAST - nxt_cnt;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (bit_pos == CW'(i)) sel_bit = held[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_OFF;
      fall_cnt   <= '0;
      mode_taken <= 1'b0;
      mode_q     <= 1'b0;
      held       <= '0;
      data_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else if (hiz_s) begin
      phase      <= PH_OFF;
      fall_cnt   <= '0;
      mode_taken <= 1'b0;
      data_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      case (phase)
        PH_OFF: if (sel_fall) begin
          phase      <= PH_RUN;
          fall_cnt   <= '0;
          mode_taken <= 1'b0;
          data_q     <= 1'b0;
          drive_q    <= 1'b1;
        end
        PH_RUN: begin
          if (sck_rise && !mode_taken) begin
            mode_q     <= fmt_unipolar;
            mode_taken <= 1'b1;
          end
          if (sck_fall) begin
            fall_cnt <= nxt_cnt;
            if (nxt_cnt == K_HOLD) held <= code;
            if (nxt_cnt >= K_LEAD) data_q <= sel_bit;
            if (nxt_cnt == K_LAST) phase <= PH_TAIL;
          end
        end
        PH_TAIL: if (sck_rise) begin
          phase    <= PH_OFF;
          fall_cnt <= '0;
          data_q   <= 1'b0;
          drive_q  <= 1'b0;
        end
        default: phase <= PH_OFF;
      endcase
    end
  end

  assign sdo_bit = data_q;
  assign sdo_en  = drive_q & ~hiz_req;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) |-> (!drive_q && !data_q));                     // R7
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && fall_cnt < K_LEAD) |-> !data_q);              // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= K_LAST);                                              // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_taken && $past(mode_taken)) |-> $stable(mode_q));           // R5
  AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && sel_fall && !sck_fall && !hiz_s)
      |=> (fall_cnt == $past(fall_cnt)));                             // R8
  AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_s |=> (phase == PH_OFF && !sdo_en));                          // R9
  AST_TAIL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TAIL && sck_rise && !hiz_s) |=> !drive_q);           // R7
endmodule

// File: tb/sar8_serial_port_bench.sv
module sar8_serial_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       hiz_req = 1'b0;
  logic       ser_clk = 1'b0;
  logic       fmt_unipolar = 1'b1;
  logic [7:0] sample_word = 8'h00;
  logic       sdo_bit, sdo_en;

  always #4 clk = ~clk;

  sar8_serial_port u_sar8_serial_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .hiz_req(hiz_req),
    .ser_clk(ser_clk), .fmt_unipolar(fmt_unipolar),
    .sample_word(sample_word), .sdo_bit(sdo_bit), .sdo_en(sdo_en)
  );

  typedef struct { logic b; string tag; int idx; } exp_t;
  exp_t exp_q[$];
  event smp;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  task automatic check(bit ok, string tag, string what, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected bit per sampling point
  always @(smp) begin
    exp_t e;
    if (exp_q.size() == 0) check(1'b0, "R3", "queue empty", 8'h0, 8'h1);
    else begin
      e = exp_q.pop_front();
      check(sdo_en === 1'b1 && sdo_bit === e.b, e.tag,
            $sformatf("bit at rise %0d (en=%b)", e.idx, sdo_en),
            {7'd0, sdo_bit}, {7'd0, e.b});
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] coded(logic [7:0] s, logic uni);
    return uni ? s : (s ^ 8'h80);
  endfunction

  // mode: 0 plain, 1 sel_n bounce after rise 6, 2 sel_n released after rise 8
  task automatic frame(logic [7:0] s, logic uni, int mode, string tag);
    logic [7:0] c;
    c = coded(s, uni);
    for (int k = 1; k <= 12; k++) begin
      exp_t e;
      e.idx = k;
      e.b   = (k <= 4) ? 1'b0 : c[12 - k];
      e.tag = (k <= 4) ? "R3" : tag;
      if (k == 1) e.tag = "R2";
      exp_q.push_back(e);
    end
    sample_word = s; fmt_unipolar = uni;
    sel_n = 1'b0; half();
    for (int k = 1; k <= 12; k++) begin
      -> smp;
      #1;
      ser_clk = 1'b1; half();
      if (k == 12)
        check(sdo_en === 1'b0 && sdo_bit === 1'b0, "R7", "power-down after LSB",
              {6'd0, sdo_en, sdo_bit}, 8'h00);
      ser_clk = 1'b0;
      if (k == 1) fmt_unipolar = ~uni;     // R5: after capture
      if (k == 4) sample_word = ~s;        // R4: after hold
      half();
      if (mode == 1 && k == 6) begin       // R8 bounce
        sel_n = 1'b1; half(); sel_n = 1'b0; half();
      end
      if (mode == 2 && k == 8) begin sel_n = 1'b1; half(); end
    end
    sel_n = 1'b1; half();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    check(sdo_en === 1'b0 && sdo_bit === 1'b0, "R1", "reset state",
          {6'd0, sdo_en, sdo_bit}, 8'h00);

    hiz_req = 1'b1; half();
    sel_n = 1'b0; half(); half();
    check(sdo_en === 1'b0, "R2", "no start with hiz high", {7'd0, sdo_en}, 8'h00);
    sel_n = 1'b1; half();
    hiz_req = 1'b0; half();

    frame(8'hA5, 1'b1, 0, "R3");
    frame(8'h3C, 1'b1, 0, "R6");
    frame(8'h80, 1'b0, 0, "R6");
    frame(8'hFF, 1'b0, 0, "R6");
    frame(8'h00, 1'b0, 0, "R6");

    sel_n = 1'b0; half();
    check(sdo_en === 1'b1 && sdo_bit === 1'b0, "R10", "restart after complete cycle",
          {6'd0, sdo_en, sdo_bit}, 8'h02);
    sel_n = 1'b1; half();
    // that aborted start is cleared with hiz
    hiz_req = 1'b1; half(); hiz_req = 1'b0; half();

    frame(8'h5A, 1'b1, 1, "R8");
    frame(8'hC3, 1'b0, 2, "R8");

    // abort by hiz in mid-frame
    sample_word = 8'h96; fmt_unipolar = 1'b1;
    sel_n = 1'b0; half();
    for (int k = 1; k <= 6; k++) begin
      ser_clk = 1'b1; half(); ser_clk = 1'b0; half();
    end
    hiz_req = 1'b1; #1;
    check(sdo_en === 1'b0, "R9", "immediate tri-state", {7'd0, sdo_en}, 8'h00);
    half();
    ser_clk = 1'b1; half(); ser_clk = 1'b0; half();
    check(sdo_en === 1'b0, "R9", "stays off under hiz", {7'd0, sdo_en}, 8'h00);
    hiz_req = 1'b0; half();
    check(sdo_en === 1'b0, "R9", "no resume without sel fall", {7'd0, sdo_en}, 8'h00);
    sel_n = 1'b1; half();
    frame(8'h69, 1'b1, 0, "R9");

    check(exp_q.size() == 0, "R3", "scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule